// File: doc/BRIEF.md
# Triggered Event Builder with Frame Packing

On every level-1 accept, this block assembles one readout packet. An accept carries a 12-bit event number and a 12-bit bunch-crossing number. The block holds both in a short accept queue until the builder is free. The builder then writes a sector header and collects one fragment from each of seven 16-bit pad streams, strictly in pad order. It then takes a single 32-bit trigger word and closes the packet with a sector footer. Pad fragments are packed two 16-bit words to each 32-bit output word.

Packets go into an output FIFO that feeds the serializer. When the monitor enable is set, every word is also written into a second FIFO, which the control bus reads. A pad that stops delivering before its fragment ends is cut off after a programmable number of idle cycles, and the missing source is flagged in the footer. A full output FIFO, or a full monitor FIFO while the copy is enabled, pauses the builder. No word is lost while it waits.

Top module: `event_builder_top`

## Requirements
- R1: After reset, the block raises no output-valid or monitor-valid, and it pops no pad or trigger source until an accept has been taken.
- R2: The first word of each packet is the sector header: bits [31:28]=4'hB, [27:16]=event number, [15:12]=0, [11:0]=bunch number, taken from the accept.
- R3: Pad fragments follow the header in pad order 0 to 6. Each fragment runs from the pad's first word up to and including the first word whose bits [15:12]=4'hF. The block pops at most one pad per cycle, and only a pad whose valid is high.
- R4: Two pad words form one output word, with the earlier word in bits [15:0]. A fragment with an odd word count ends with the filler 16'hD000 in bits [31:16].
- R5: After pad 6, the block pops one 32-bit trigger word and copies it unchanged into the packet, just before the footer. It pops the trigger source only while that source's valid is high.
- R6: The last word is the sector footer: bits [31:28]=4'hE, [27:16]=event number, [15:8]=0, [7:0]=error mask. Bit p of the mask stands for pad p, and bit 7 stands for the trigger source.
- R7: If a pad shows no valid word for TMO_CYC consecutive cycles while its fragment is open, the fragment is closed and footer bit p is set. A lone pending word is flushed with the filler.
- R8: If the trigger source shows no valid word for TMO_CYC consecutive cycles, no trigger word is written and footer bit 7 is set.
- R9: Accepts that arrive while a packet is being built are queued, up to ACC_DEPTH of them. They are built in arrival order, each with its own event and bunch numbers.
- R10: The builder never writes into a full output FIFO and drops no word under back-pressure. The head word stays stable while it is not read.
- R11: While mon_en_i is high, the monitor FIFO receives the same words, in the same order, as the output FIFO. While it is low, the monitor FIFO receives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event-building clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1a_i | input | 1 | Level-1 accept strobe |
| l1a_evid_i | input | 12 | Event number of the accept |
| l1a_bcid_i | input | 12 | Bunch-crossing number of the accept |
| pad_valid_i | input | 7 | Per-pad word-available flags |
| pad_data_i | input | 112 | Head word of each pad; pad p in bits [16p+15:16p] |
| pad_pop_o | output | 7 | Per-pad pop strobes |
| trg_valid_i | input | 1 | Trigger word available |
| trg_data_i | input | 32 | Trigger word |
| trg_pop_o | output | 1 | Trigger pop strobe |
| out_rd_i | input | 1 | Serializer-side read of the output FIFO |
| out_valid_o | output | 1 | Output FIFO not empty |
| out_data_o | output | 32 | Output FIFO head word |
| mon_en_i | input | 1 | Enable the monitor copy |
| mon_rd_i | input | 1 | Read of the monitor FIFO |
| mon_valid_o | output | 1 | Monitor FIFO not empty |
| mon_data_o | output | 32 | Monitor FIFO head word |

## Verification
The assertions rely on the source-side contract. A pad's or the trigger's head word stays put until the block pops it, and a pop is only meaningful while the matching valid is high. The output reader is also assumed to assert a read only against the valid flag. The bench models each source as a queue whose valid and head word update only at clock edges after a pop. It keeps mon_en_i steady for the whole of a packet. Its fragments never place the closing nibble 4'hF in a pad header or data word.

// File: rtl/eb_pkg.sv
package eb_pkg;
    localparam int PW   = 16;
    localparam int OW   = 32;
    localparam int IDW  = 12;
    localparam int NPAD = 7;

    localparam logic [3:0]    TAG_PFTR  = 4'hF;
    localparam logic [3:0]    TAG_SHDR  = 4'hB;
    localparam logic [3:0]    TAG_SFTR  = 4'hE;
    localparam logic [PW-1:0] FILL_WORD = 16'hD000;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_PAD, S_FLUSH, S_TRG, S_FTR
    } bld_state_e;

    typedef struct packed {
        logic [IDW-1:0] evid;
        logic [IDW-1:0] bcid;
    } acc_t;
endpackage

// File: rtl/eb_fifo.sv
module eb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rp;
        logic [AW-1:0] wp;
        logic [CW-1:0] cnt;
    } fifo_reg_t;

    fifo_reg_t    r_q, r_d;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_wr, do_rd;

    assign empty   = (r_q.cnt == '0);
    assign full    = (r_q.cnt == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem_q[r_q.rp];

    always_comb begin
        r_d = r_q;
        if (do_wr) r_d.wp = (r_q.wp == AW'(DEPTH - 1)) ? '0 : r_q.wp + 1'b1;
        if (do_rd) r_d.rp = (r_q.rp == AW'(DEPTH - 1)) ? '0 : r_q.rp + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[r_q.wp] <= wr_data;
    end
endmodule

// File: rtl/eb_pad_sel.sv
module eb_pad_sel
    import eb_pkg::*;
(
    input  logic [NPAD-1:0]    valid_i,
    input  logic [NPAD*PW-1:0] data_i,
    input  logic [2:0]         sel_i,
    input  logic               pop_i,
    output logic               sel_valid_o,
    output logic [PW-1:0]      sel_data_o,
    output logic [NPAD-1:0]    pop_o
);
    always_comb begin
        sel_valid_o = 1'b0;
        sel_data_o  = '0;
        for (int i = 0; i < NPAD; i++) begin
            if (sel_i == 3'(i)) begin
                sel_valid_o = valid_i[i];
                sel_data_o  = data_i[i*PW +: PW];
            end
        end
    end

    for (genvar g = 0; g < NPAD; g++) begin : g_pop
        assign pop_o[g] = pop_i && (sel_i == 3'(g));
    end
endmodule

// File: rtl/eb_builder.sv
module eb_builder
    import eb_pkg::*;
#(
    parameter int TMO_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_empty_i,
    input  acc_t          acc_i,
    output logic          acc_pop_o,
    output logic [2:0]    psel_o,
    input  logic          pvalid_i,
    input  logic [PW-1:0] pdata_i,
    output logic          ppop_o,
    input  logic          trg_valid_i,
    input  logic [OW-1:0] trg_data_i,
    output logic          trg_pop_o,
    input  logic          stall_i,
    output logic          wr_en_o,
    output logic [OW-1:0] wr_data_o
);
    localparam int TW = $clog2(TMO_CYC + 1);

    typedef struct packed {
        bld_state_e     st;
        logic [2:0]     idx;
        logic [IDW-1:0] evid;
        logic [IDW-1:0] bcid;
        logic [PW-1:0]  half;
        logic           hv;
        logic [7:0]     err;
        logic [TW-1:0]  tmo;
    } bld_reg_t;

    bld_reg_t r_q, r_d;
    logic     adv;
    logic     is_ftr;
    logic     tmo_hit;

    assign psel_o  = r_q.idx;
    assign is_ftr  = (pdata_i[PW-1:PW-4] == TAG_PFTR);
    assign tmo_hit = (r_q.tmo == TW'(TMO_CYC - 1));

    always_comb begin
        r_d       = r_q;
        adv       = 1'b0;
        acc_pop_o = 1'b0;
        ppop_o    = 1'b0;
        trg_pop_o = 1'b0;
        wr_en_o   = 1'b0;
        wr_data_o = '0;
        case (r_q.st)
            S_IDLE: begin
                if (!acc_empty_i) begin
                    acc_pop_o = 1'b1;
                    r_d.evid  = acc_i.evid;
                    r_d.bcid  = acc_i.bcid;
                    r_d.err   = '0;
                    r_d.st    = S_HDR;
                end
            end
            S_HDR: begin
                if (!stall_i) begin
                    wr_en_o   = 1'b1;
                    wr_data_o = {TAG_SHDR, r_q.evid, 4'h0, r_q.bcid};
                    r_d.st    = S_PAD;
                    r_d.idx   = '0;
                    r_d.hv    = 1'b0;
                    r_d.tmo   = '0;
                end
            end
            S_PAD: begin
                if (pvalid_i) begin
                    r_d.tmo = '0;
                    if (r_q.hv) begin
                        if (!stall_i) begin
                            wr_en_o   = 1'b1;
                            wr_data_o = {pdata_i, r_q.half};
                            ppop_o    = 1'b1;
                            r_d.hv    = 1'b0;
                            adv       = is_ftr;
                        end
                    end else begin
                        ppop_o   = 1'b1;
                        r_d.half = pdata_i;
                        r_d.hv   = 1'b1;
                        if (is_ftr) r_d.st = S_FLUSH;
                    end
                end else if (tmo_hit) begin
                    r_d.err[r_q.idx] = 1'b1;
                    if (r_q.hv) r_d.st = S_FLUSH;
                    else        adv    = 1'b1;
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            S_FLUSH: begin
                if (!stall_i) begin
                    wr_en_o   = 1'b1;
                    wr_data_o = {FILL_WORD, r_q.half};
                    r_d.hv    = 1'b0;
                    adv       = 1'b1;
                end
            end
            S_TRG: begin
                if (trg_valid_i) begin
                    if (!stall_i) begin
                        wr_en_o   = 1'b1;
                        wr_data_o = trg_data_i;
                        trg_pop_o = 1'b1;
                        r_d.st    = S_FTR;
                    end
                end else if (tmo_hit) begin
                    r_d.err[7] = 1'b1;
                    r_d.st     = S_FTR;
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            S_FTR: begin
                if (!stall_i) begin
                    wr_en_o   = 1'b1;
                    wr_data_o = {TAG_SFTR, r_q.evid, 8'h00, r_q.err};
                    r_d.st    = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (adv) begin
            r_d.tmo = '0;
            if (r_q.idx == 3'(NPAD - 1)) begin
                r_d.st = S_TRG;
            end else begin
                r_d.st  = S_PAD;
                r_d.idx = r_q.idx + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/event_builder_top.sv
module event_builder_top
    import eb_pkg::*;
#(
    parameter int TMO_CYC   = 64,
    parameter int ACC_DEPTH = 4,
    parameter int OUT_DEPTH = 16,
    parameter int MON_DEPTH = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               l1a_i,
    input  logic [IDW-1:0]     l1a_evid_i,
    input  logic [IDW-1:0]     l1a_bcid_i,
    input  logic [NPAD-1:0]    pad_valid_i,
    input  logic [NPAD*PW-1:0] pad_data_i,
    output logic [NPAD-1:0]    pad_pop_o,
    input  logic               trg_valid_i,
    input  logic [OW-1:0]      trg_data_i,
    output logic               trg_pop_o,
    input  logic               out_rd_i,
    output logic               out_valid_o,
    output logic [OW-1:0]      out_data_o,
    input  logic               mon_en_i,
    input  logic               mon_rd_i,
    output logic               mon_valid_o,
    output logic [OW-1:0]      mon_data_o
);
    localparam int AccW = 2 * IDW;

    logic            acc_empty, acc_full, acc_pop;
    logic [AccW-1:0] acc_raw;
    logic [2:0]      psel;
    logic            pvalid, ppop;
    logic [PW-1:0]   pdata;
    logic            bld_wr, stall;
    logic [OW-1:0]   bld_data;
    logic            out_empty, out_full;
    logic            mon_empty, mon_full, mon_wr;

    assign stall       = out_full || (mon_en_i && mon_full);
    assign mon_wr      = bld_wr && mon_en_i;
    assign out_valid_o = !out_empty;
    assign mon_valid_o = !mon_empty;

    eb_fifo #(.W(AccW), .DEPTH(ACC_DEPTH)) u_acc_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(l1a_i), .wr_data({l1a_evid_i, l1a_bcid_i}),
        .rd_en(acc_pop), .rd_data(acc_raw),
        .empty(acc_empty), .full(acc_full)
    );

    eb_pad_sel u_sel (
        .valid_i(pad_valid_i), .data_i(pad_data_i), .sel_i(psel), .pop_i(ppop),
        .sel_valid_o(pvalid), .sel_data_o(pdata), .pop_o(pad_pop_o)
    );

    eb_builder #(.TMO_CYC(TMO_CYC)) u_bld (
        .clk(clk), .rst_n(rst_n),
        .acc_empty_i(acc_empty), .acc_i(acc_t'(acc_raw)), .acc_pop_o(acc_pop),
        .psel_o(psel), .pvalid_i(pvalid), .pdata_i(pdata), .ppop_o(ppop),
        .trg_valid_i(trg_valid_i), .trg_data_i(trg_data_i), .trg_pop_o(trg_pop_o),
        .stall_i(stall), .wr_en_o(bld_wr), .wr_data_o(bld_data)
    );

    eb_fifo #(.W(OW), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bld_wr), .wr_data(bld_data),
        .rd_en(out_rd_i), .rd_data(out_data_o),
        .empty(out_empty), .full(out_full)
    );

    eb_fifo #(.W(OW), .DEPTH(MON_DEPTH)) u_mon_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mon_wr), .wr_data(bld_data),
        .rd_en(mon_rd_i), .rd_data(mon_data_o),
        .empty(mon_empty), .full(mon_full)
    );
endmodule

// File: rtl/eb_checker.sv
module eb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  pad_valid,
    input logic [6:0]  pad_pop,
    input logic        trg_valid,
    input logic        trg_pop,
    input logic        out_wr,
    input logic        out_full,
    input logic        out_valid,
    input logic        out_rd,
    input logic [31:0] out_data,
    input logic        mon_wr,
    input logic        mon_full
);
    // R3: a pad is only popped while it presents a word
    p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pop & ~pad_valid) == 7'd0);

    // R3: at most one pad popped in any cycle
    p_one_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pad_pop));

    // R5: trigger popped only while valid
    p_trg_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trg_pop |-> trg_valid);

    // R10: no write into a full output FIFO
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> !out_full);

    // R10: unread head word holds
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_rd) |=> (out_valid && $stable(out_data)));

    // R11: the monitor copy never lands in a full monitor FIFO
    p_mon_space_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mon_wr |-> !mon_full);
endmodule

bind event_builder_top eb_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .pad_valid(pad_valid_i), .pad_pop(pad_pop_o),
    .trg_valid(trg_valid_i), .trg_pop(trg_pop_o),
    .out_wr(bld_wr), .out_full(out_full),
    .out_valid(out_valid_o), .out_rd(out_rd_i), .out_data(out_data_o),
    .mon_wr(mon_wr), .mon_full(mon_full)
);

// File: tb/tb_event_builder_top.sv
module tb_event_builder_top;
    localparam int TMO = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         l1a_i = 1'b0;
    logic [11:0]  l1a_evid_i = '0, l1a_bcid_i = '0;
    logic [6:0]   pad_valid_i = '0;
    logic [111:0] pad_data_i = '0;
    logic [6:0]   pad_pop_o;
    logic         trg_valid_i = 1'b0;
    logic [31:0]  trg_data_i = '0;
    logic         trg_pop_o;
    logic         out_rd_i = 1'b0;
    logic         out_valid_o;
    logic [31:0]  out_data_o;
    logic         mon_en_i = 1'b0;
    logic         mon_rd_i = 1'b0;
    logic         mon_valid_o;
    logic [31:0]  mon_data_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] pq [0:6][$];
    logic [31:0] tq [$];
    logic [31:0] expq [$];
    logic [31:0] got [$];
    logic [31:0] mgot [$];
    logic [6:0]  popl = '0;
    logic        tpopl = 1'b0;
    bit          col_en = 1'b1;

    event_builder_top #(.TMO_CYC(TMO)) dut (.*);

    always #10 clk = ~clk;

    // source models: sample the pops away from the edge, apply them at the edge
    always @(negedge clk) begin
        popl  = pad_pop_o;
        tpopl = trg_pop_o;
    end

    always @(posedge clk) begin
        for (int p = 0; p < 7; p++) begin
            if (popl[p] && pq[p].size() != 0) void'(pq[p].pop_front());
            pad_valid_i[p]          <= (pq[p].size() != 0);
            pad_data_i[p*16 +: 16]  <= (pq[p].size() != 0) ? pq[p][0] : 16'h0;
        end
        if (tpopl && tq.size() != 0) void'(tq.pop_front());
        trg_valid_i <= (tq.size() != 0);
        trg_data_i  <= (tq.size() != 0) ? tq[0] : 32'h0;
    end

    // output and monitor readers
    always @(negedge clk) begin
        out_rd_i = 1'b0;
        mon_rd_i = 1'b0;
        if (col_en && out_valid_o) begin
            got.push_back(out_data_o);
            out_rd_i = 1'b1;
        end
        if (mon_valid_o) begin
            mgot.push_back(mon_data_o);
            mon_rd_i = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // lens[p]: data-word count; -1 = pad silent; -2 = header only, then silent
    task automatic plan_event(input int ev, input int bc, input int lens [7], input bit trg_on);
        logic [15:0] w [$];
        logic [7:0]  err = 8'h00;
        expq.push_back({4'hB, 12'(ev), 4'h0, 12'(bc)});
        for (int p = 0; p < 7; p++) begin
            w.delete();
            if (lens[p] == -1) begin
                err[p] = 1'b1;
            end else begin
                w.push_back({4'hA, 4'(p), 8'(ev)});
                if (lens[p] == -2) err[p] = 1'b1;
                else begin
                    for (int k = 0; k < lens[p]; k++) w.push_back({4'h3, 4'(p), 8'(k + ev * 5)});
                    w.push_back({4'hF, 4'(p), 8'(ev)});
                end
            end
            foreach (w[i]) pq[p].push_back(w[i]);
            for (int k = 0; k + 1 < w.size(); k += 2) expq.push_back({w[k+1], w[k]});
            if (w.size() % 2 == 1) expq.push_back({16'hD000, w[w.size()-1]});
        end
        if (trg_on) begin
            tq.push_back({8'h7C, 12'(ev), 12'(bc)});
            expq.push_back({8'h7C, 12'(ev), 12'(bc)});
        end else err[7] = 1'b1;
        expq.push_back({4'hE, 12'(ev), 8'h00, err});
    endtask

    task automatic fire(input int ev, input int bc);
        @(negedge clk);
        l1a_i = 1'b1; l1a_evid_i = 12'(ev); l1a_bcid_i = 12'(bc);
        @(negedge clk);
        l1a_i = 1'b0;
    endtask

    task automatic wait_out();
        for (int i = 0; i < 6000 && got.size() < expq.size(); i++) @(posedge clk);
        repeat (8) @(posedge clk);
    endtask

    task automatic compare(input string tag);
        check(got.size() == expq.size(), tag, "word count", got.size(), expq.size());
        for (int i = 0; i < expq.size() && i < got.size(); i++)
            check(got[i] == expq[i], (i == 0) ? "R2" : (i == expq.size()-1) ? "R6" : tag,
                  $sformatf("word %0d", i), got[i], expq[i]);
    endtask

    task automatic clear();
        got.delete(); mgot.delete(); expq.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1", "out_valid after reset", 32'(out_valid_o), 0);
        check(mon_valid_o == 1'b0, "R1", "mon_valid after reset", 32'(mon_valid_o), 0);
        check(pad_pop_o == 7'd0, "R1", "pad pops after reset", 32'(pad_pop_o), 0);
        check(trg_pop_o == 1'b0, "R1", "trg pop after reset", 32'(trg_pop_o), 0);
    endtask

    // R2 R3 R4 R5 R6 R11: mixed odd/even fragment lengths, monitor copy on
    task automatic t_basic();
        clear();
        mon_en_i = 1'b1;
        plan_event(12'h123, 12'h0AB, '{0, 1, 2, 3, 4, 5, 6}, 1'b1);
        fire(12'h123, 12'h0AB);
        wait_out();
        compare("R3/R4/R5");
        check(mgot.size() == expq.size(), "R11", "monitor count", mgot.size(), expq.size());
        for (int i = 0; i < expq.size() && i < mgot.size(); i++)
            check(mgot[i] == expq[i], "R11", $sformatf("monitor word %0d", i), mgot[i], expq[i]);
        mon_en_i = 1'b0;
    endtask

    // R11: with the copy disabled nothing reaches the monitor FIFO
    task automatic t_mon_off();
        clear();
        plan_event(7, 9, '{1, 1, 1, 1, 1, 1, 1}, 1'b1);
        fire(7, 9);
        wait_out();
        compare("R3/R4");
        check(mgot.size() == 0 && !mon_valid_o, "R11", "monitor words while off", mgot.size(), 0);
    endtask

    // R7 R8: silent pad 3 and missing trigger word
    task automatic t_timeout();
        clear();
        plan_event(40, 41, '{2, 2, 2, -1, 2, 2, 2}, 1'b0);
        fire(40, 41);
        wait_out();
        compare("R7/R8");
    endtask

    // R7: pad 5 delivers only its header; the lone word is flushed with the filler
    task automatic t_half_flush();
        clear();
        plan_event(50, 3, '{1, 0, 1, 0, 1, -2, 0}, 1'b1);
        fire(50, 3);
        wait_out();
        compare("R7/R4");
    endtask

    // R9: three accepts back to back, built in arrival order
    task automatic t_queue();
        clear();
        plan_event(100, 200, '{0, 1, 0, 1, 0, 1, 0}, 1'b1);
        plan_event(101, 201, '{2, 0, 3, 0, 1, 0, 2}, 1'b1);
        plan_event(102, 202, '{1, 1, 1, 1, 1, 1, 1}, 1'b1);
        @(negedge clk);
        l1a_i = 1'b1; l1a_evid_i = 12'd100; l1a_bcid_i = 12'd200;
        @(negedge clk);
        l1a_evid_i = 12'd101; l1a_bcid_i = 12'd201;
        @(negedge clk);
        l1a_evid_i = 12'd102; l1a_bcid_i = 12'd202;
        @(negedge clk);
        l1a_i = 1'b0;
        wait_out();
        compare("R9");
    endtask

    // R10: reader held off until the output FIFO fills, then released
    task automatic t_stall();
        clear();
        col_en = 1'b0;
        plan_event(300, 301, '{6, 6, 6, 6, 6, 6, 6}, 1'b1);
        fire(300, 301);
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(out_valid_o == 1'b1, "R10", "output held while full", 32'(out_valid_o), 1);
        check(pq[6].size() != 0, "R10", "pad 6 left unread while stalled", pq[6].size(), 1);
        col_en = 1'b1;
        wait_out();
        compare("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        t_reset();
        t_basic();
        t_mon_off();
        t_timeout();
        t_half_flush();
        t_queue();
        t_stall();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule